// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side of a parallel flash device. It decides whether a program or erase operation that was already issued has finished. After a start pulse it fetches pairs of byte-wide status words through a request/acknowledge read channel. It treats the operation as still running while status bit 6 changes from one read to the next. Status bit 5 is the device's timeout indicator.

A raised timeout indicator is not taken as final on its own word. The block fetches one more pair to catch an operation that completed at the same moment the indicator rose. If bit 6 still flips in that extra pair, the block reports failure and sends the device a one-cycle reset command (0xF0 on the low byte) so that it returns to array reads. Every run ends with a one-cycle completion pulse and a pass flag. An abort input stops a poll that is in progress. The next start always begins again from a fresh pair of reads.

Top module: `tbp_poller`

## Requirements
- R1: After reset, rd_req, wr_req, done and pass are all low.
- R2: A start pulse in idle begins a poll. Every read request is held high until rd_ack is seen, and rd_req and wr_req are never high together.
- R3: If the first two reads of a poll agree on bit 6 (bit 6 = toggle bit), the result is pass after exactly two reads, and no command write is made.
- R4: If bit 6 differs within a pair and bit 5 of the second read of that pair is low, another pair is read and the same rules apply to it. Bit 5 of the first read of a pair is ignored.
- R5: If bit 6 differs and bit 5 (bit 5 = timeout flag, active high) of the second read is high, one re-check pair is read. If that pair agrees on bit 6, the result is pass.
- R6: If the re-check pair still differs on bit 6, the result is fail. Exactly one write is then made with wr_data = 0xF0, held until wr_ack.
- R7: done is a single-cycle pulse. It is high two cycles after the cycle in which the deciding read is acknowledged, or one cycle after the cycle in which the reset write is acknowledged.
- R8: pass is cleared when a start is accepted. It is set together with done on a pass result and keeps its value until the next start.
- R9: abort while a read is pending or a pair is being judged returns the block to idle with no done pulse and no write. The next start begins again with two fresh reads.
- R10: A start pulse during a poll is ignored: the read count and the outcome do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a poll (used only when idle) |
| abort | input | 1 | Stop the current poll during reads or judging |
| rd_req | output | 1 | Status read request, held until acknowledged |
| rd_ack | input | 1 | Read acknowledge; rd_data is valid in this cycle |
| rd_data | input | DW | Status word returned by the device |
| wr_req | output | 1 | Command write request, held until acknowledged |
| wr_ack | input | 1 | Write acknowledge |
| wr_data | output | DW | Command byte (0xF0 while wr_req is high) |
| done | output | 1 | One-cycle end-of-poll pulse |
| pass | output | 1 | Outcome: 1 means the operation completed |

## Verification
Every acknowledged read goes through one registered judging step, so done is due two cycles after the acknowledge that decides the result. Through the reset write, done is due one cycle after the write acknowledge. The write request itself is due two cycles after the failing pair's last acknowledge. The bench's model logs the cycle of every acknowledge it issues and from that computes the exact cycle in which done and wr_req must be high. It compares both outputs with those predictions at every falling edge, so a pulse that comes a cycle early or a cycle late is caught. Read counts, write counts and the pass flag are compared once done has been seen. Responder latency is varied to move these deadlines.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_A,
      ST_RD_B,
      ST_EVAL,
      ST_WR,
      ST_DONE
   } tbp_state_e;

   typedef enum logic [1:0] {
      VD_PASS,
      VD_FAIL,
      VD_AGAIN,
      VD_RECHECK
   } tbp_verdict_e;
endpackage

// File: rtl/tbp_sample.sv
module tbp_sample #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap_en,
   input  logic          slot_b,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] word_a,
   output logic [DW-1:0] word_b
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_a <= '0;
         word_b <= '0;
      end else if (cap_en) begin
         if (slot_b) word_b <= din;
         else        word_a <= din;
      end
   end
endmodule

// File: rtl/tbp_judge.sv
module tbp_judge
   import tbp_pkg::*;
#(
   parameter int DW        = 8,
   parameter int TOG_BIT   = 6,
   parameter int TMO_BIT   = 5,
   parameter bit TMO_HIGH  = 1'b1
) (
   input  logic [DW-1:0] word_a,
   input  logic [DW-1:0] word_b,
   input  logic          recheck_q,
   output tbp_verdict_e  verdict
);
   logic flipped;
   logic timed_out;

   assign flipped = word_a[TOG_BIT] ^ word_b[TOG_BIT];

   generate
      if (TMO_HIGH) begin : g_tmo_hi
         assign timed_out = word_b[TMO_BIT];
      end else begin : g_tmo_lo
         assign timed_out = ~word_b[TMO_BIT];
      end
   endgenerate

   always_comb begin
      if (!flipped)       verdict = VD_PASS;
      else if (recheck_q) verdict = VD_FAIL;
      else if (timed_out) verdict = VD_RECHECK;
      else                verdict = VD_AGAIN;
   end
endmodule

// File: rtl/tbp_ctrl.sv
module tbp_ctrl
   import tbp_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         abort,
   input  logic         rd_ack,
   input  logic         wr_ack,
   input  tbp_verdict_e verdict,
   output tbp_state_e   state,
   output logic         recheck_q,
   output logic         pass_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         recheck_q <= 1'b0;
         pass_q    <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state     <= ST_RD_A;
                  recheck_q <= 1'b0;
                  pass_q    <= 1'b0;
               end
            end
            ST_RD_A: begin
               if (abort)       state <= ST_IDLE;
               else if (rd_ack) state <= ST_RD_B;
            end
            ST_RD_B: begin
               if (abort)       state <= ST_IDLE;
               else if (rd_ack) state <= ST_EVAL;
            end
            ST_EVAL: begin
               if (abort) begin
                  state <= ST_IDLE;
               end else begin
                  case (verdict)
                     VD_PASS: begin
                        pass_q <= 1'b1;
                        state  <= ST_DONE;
                     end
                     VD_FAIL:  state <= ST_WR;
                     VD_RECHECK: begin
                        recheck_q <= 1'b1;
                        state     <= ST_RD_A;
                     end
                     default:  state <= ST_RD_A;
                  endcase
               end
            end
            ST_WR: begin
               if (wr_ack) state <= ST_DONE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tbp_poller.sv
module tbp_poller
   import tbp_pkg::*;
#(
   parameter int          DW       = 8,
   parameter int          TOG_BIT  = 6,
   parameter int          TMO_BIT  = 5,
   parameter bit          TMO_HIGH = 1'b1,
   parameter logic [7:0]  RST_CMD  = 8'hF0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          abort,
   output logic          rd_req,
   input  logic          rd_ack,
   input  logic [DW-1:0] rd_data,
   output logic          wr_req,
   input  logic          wr_ack,
   output logic [DW-1:0] wr_data,
   output logic          done,
   output logic          pass
);
   localparam int CMD_W = 8;

   generate
      if (DW < CMD_W) begin : g_bad_dw
         $error("tbp_poller: DW must be at least 8");
      end
      if (TOG_BIT >= DW || TMO_BIT >= DW || TOG_BIT == TMO_BIT) begin : g_bad_bits
         $error("tbp_poller: status bit positions out of range or equal");
      end
   endgenerate

   tbp_state_e   state;
   tbp_verdict_e verdict;
   logic         recheck_q;
   logic         pass_q;
   logic [DW-1:0] word_a;
   logic [DW-1:0] word_b;
   logic         cap_en;

   assign rd_req = (state == ST_RD_A) || (state == ST_RD_B);
   assign wr_req = (state == ST_WR);
   assign done   = (state == ST_DONE);
   assign pass   = pass_q;
   assign cap_en = rd_req & rd_ack & ~abort;

   generate
      if (DW > CMD_W) begin : g_wide
         assign wr_data = wr_req ? {{(DW-CMD_W){1'b0}}, RST_CMD} : '0;
      end else begin : g_byte
         assign wr_data = wr_req ? RST_CMD : '0;
      end
   endgenerate

   tbp_sample #(.DW(DW)) u_sample (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_en (cap_en),
      .slot_b (state == ST_RD_B),
      .din    (rd_data),
      .word_a (word_a),
      .word_b (word_b)
   );

   tbp_judge #(
      .DW       (DW),
      .TOG_BIT  (TOG_BIT),
      .TMO_BIT  (TMO_BIT),
      .TMO_HIGH (TMO_HIGH)
   ) u_judge (
      .word_a    (word_a),
      .word_b    (word_b),
      .recheck_q (recheck_q),
      .verdict   (verdict)
   );

   tbp_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .abort     (abort),
      .rd_ack    (rd_ack),
      .wr_ack    (wr_ack),
      .verdict   (verdict),
      .state     (state),
      .recheck_q (recheck_q),
      .pass_q    (pass_q)
   );
endmodule

// File: rtl/tbp_poller_chk.sv
module tbp_poller_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic abort,
   input logic rd_req,
   input logic rd_ack,
   input logic wr_req,
   input logic wr_ack,
   input logic done,
   input logic pass
);
   a_r2_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req && wr_req));

   a_r2_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack && !abort) |=> rd_req);

   a_r6_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_ack) |=> wr_req);

   a_r6_fail_nopass: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_req) |-> !pass);

   a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(rd_req && rd_ack, 2) || $past(wr_req && wr_ack)));

   a_r8_pass_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pass) |-> (done || $past(start)));

   a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && rd_req) |=> (!rd_req && !wr_req && !done));
endmodule

bind tbp_poller tbp_poller_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .abort  (abort),
   .rd_req (rd_req),
   .rd_ack (rd_ack),
   .wr_req (wr_req),
   .wr_ack (wr_ack),
   .done   (done),
   .pass   (pass)
);

// File: tb/tbp_poller_tb.sv
`timescale 1ns/1ps
module tbp_poller_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       abort = 1'b0;
   logic       rd_req;
   logic       rd_ack = 1'b0;
   logic [7:0] rd_data = 8'h00;
   logic       wr_req;
   logic       wr_ack = 1'b0;
   logic [7:0] wr_data;
   logic       done;
   logic       pass;

   int errors = 0;
   int checks = 0;
   int cyc = 0;

   logic [7:0] rq[$];
   int  lat = 0;
   int  rcnt = 0, wcnt = 0;
   int  nreads = 0, nwrites = 0, ndone = 0;
   bit  armed = 0;
   int  exp_reads = 0;
   bit  exp_pass = 0, exp_wr = 0;
   int  due = -1, wr_from = -1;
   string cur_req = "R3";

   always #2 clk = ~clk;
   always @(posedge clk) cyc++;

   tbp_poller u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
      .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
      .wr_req(wr_req), .wr_ack(wr_ack), .wr_data(wr_data),
      .done(done), .pass(pass)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // reference outcome from the rules: pairs, recheck on timeout flag
   task automatic predict(input logic [7:0] v[$]);
      int i = 0;
      bit rc = 0;
      exp_pass = 0; exp_wr = 0; exp_reads = 0;
      while (i + 1 < v.size()) begin
         logic [7:0] a = v[i];
         logic [7:0] b = v[i+1];
         i += 2;
         if (a[6] == b[6]) begin exp_pass = 1; break; end
         else if (rc) begin exp_wr = 1; break; end
         else if (b[5]) rc = 1;
      end
      exp_reads = i;
   endtask

   // per-cycle model compare plus responders
   always @(negedge clk) begin
      if (done) ndone++;
      if (rst_n) chk(!(rd_req && wr_req), "R2", "rd_req and wr_req together", 1, 0);
      if (armed) begin
         chk(done == (cyc == due), "R7", "done timing", done, cyc == due);
         chk(wr_req == (exp_wr && wr_from >= 0 && cyc >= wr_from && nwrites == 0),
             "R6", "wr_req timing", wr_req,
             exp_wr && wr_from >= 0 && cyc >= wr_from && nwrites == 0);
      end
      if (rd_ack) rd_ack = 1'b0;
      else if (rd_req) begin
         if (rcnt >= lat) begin
            rd_ack  = 1'b1;
            rd_data = (rq.size() > 0) ? rq.pop_front() : 8'h00;
            nreads++;
            rcnt = 0;
            if (armed && nreads == exp_reads) begin
               if (exp_wr) wr_from = cyc + 2;
               else        due = cyc + 2;
            end
         end else rcnt++;
      end else rcnt = 0;
      if (wr_ack) wr_ack = 1'b0;
      else if (wr_req) begin
         if (wcnt >= lat) begin
            wr_ack = 1'b1;
            nwrites++;
            wcnt = 0;
            chk(wr_data == 8'hF0, "R6", "reset command byte", wr_data, 8'hF0);
            if (armed) due = cyc + 1;
         end else wcnt++;
      end else wcnt = 0;
   end

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic run(input logic [7:0] v[$], input int l, input string req,
                      input bit extra_start);
      int w = 0;
      lat = l; cur_req = req;
      predict(v);
      rq = v;
      nreads = 0; nwrites = 0; ndone = 0; due = -1; wr_from = -1;
      armed = 1;
      pulse_start();
      chk(pass == 1'b0, "R8", "pass cleared by start", pass, 0);
      if (extra_start) begin
         repeat (3) @(negedge clk);
         start = 1'b1;
         @(negedge clk); start = 1'b0;
      end
      while (ndone == 0 && w < 400) begin @(negedge clk); w++; end
      repeat (3) @(negedge clk);
      armed = 0;
      chk(ndone == 1, req, "done pulse count", ndone, 1);
      chk(nreads == exp_reads, req, "status reads", nreads, exp_reads);
      chk(nwrites == int'(exp_wr), req, "reset writes", nwrites, exp_wr);
      chk(pass == exp_pass, req, "pass flag", pass, exp_pass);
      repeat (4) @(negedge clk);
      chk(pass == exp_pass, "R8", "pass held while idle", pass, exp_pass);
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      checks++;
      $display("FAIL R2 watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] v[$];
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!rd_req && !wr_req && !done && !pass, "R1", "reset outputs",
          {rd_req, wr_req, done, pass}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!rd_req && !done, "R1", "idle after reset", {rd_req, done}, 0);

      v = '{8'h40, 8'h40};                       run(v, 0, "R3", 0);
      v = '{8'h9F, 8'h1B};                       run(v, 1, "R3", 0);
      v = '{8'h00, 8'h40, 8'h40, 8'h40};         run(v, 0, "R4", 0);
      v = '{8'h20, 8'h40, 8'h00, 8'h00};         run(v, 2, "R4", 0);
      v = '{8'h00, 8'h60, 8'h20, 8'h20};         run(v, 0, "R5", 0);
      v = '{8'h40, 8'h20, 8'h00, 8'h40};         run(v, 2, "R6", 0);
      v = '{8'h00, 8'h40, 8'h40, 8'h00, 8'h00, 8'h60, 8'h40, 8'h00};
      run(v, 1, "R6", 0);
      v = '{8'h00, 8'h40, 8'h40, 8'h00, 8'h00, 8'h40, 8'h40, 8'h40};
      run(v, 3, "R10", 1);

      // R9: abort during a long toggling poll
      rq.delete();
      for (int k = 0; k < 30; k++) rq.push_back((k % 2) ? 8'h40 : 8'h00);
      lat = 1; nwrites = 0; ndone = 0;
      pulse_start();
      repeat (7) @(negedge clk);
      while (!rd_req) @(negedge clk);
      abort = 1'b1;
      @(negedge clk); abort = 1'b0;
      repeat (10) @(negedge clk);
      chk(ndone == 0, "R9", "no done after abort", ndone, 0);
      chk(nwrites == 0, "R9", "no write after abort", nwrites, 0);
      chk(!rd_req, "R9", "reads stop after abort", rd_req, 0);
      chk(pass == 1'b0, "R9", "pass low after abort", pass, 0);
      rq.delete();
      v = '{8'h40, 8'h40};                       run(v, 0, "R9", 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule